// File: doc/BRIEF.md
# Element-Width Polymorphic Register File

This block is an integer register file of 64-bit registers in which every register can also be treated as a packed row of narrower lanes. An access names a register, a 2-bit width code and an element offset. A read returns one lane, zero-extended to the full register width. A write is either vector or scalar. A vector write replaces a single lane and leaves every other bit as it was. A scalar write replaces the whole register.

An offset can be larger than the number of lanes in one register. In that case the access moves on into the registers that follow. An access that would land beyond the last register is flagged and has no effect.

A small element sequencer drives a demonstration add datapath. After a start pulse it steps an element index from 0 up to VL-1, one index per clock. An element runs only when its bit in the predicate mask is set. A running element adds two source lanes at that index and writes the sum into the destination at the same index. The sequencer is what exercises the indexed access paths.

Top module: `ewrf_top`

## Requirements
- R1: After reset every register reads as zero, and `op_busy` and `op_done` are low.
- R2: The width code selects the lane size: 0 is the full 64 bits, 1 is 8 bits, 2 is 16 bits and 3 is 32 bits. Lane k of a register occupies bits [k*w+w-1 : k*w], where w is the lane size. A read returns the addressed lane zero-extended to 64 bits, combinationally.
- R3: A vector write (`wr_vec`=1) replaces only the addressed lane. All other bits of every register are unchanged.
- R4: A scalar write (`wr_vec`=0) ignores the offset. It stores the low w bits of `wr_data`, zero-extended, into all 64 bits of the named register.
- R5: An offset of at least 64/w lanes continues into the following registers. The register used is reg + off/(64/w), and the lane used is off mod (64/w).
- R6: If the register an access lands on is 128 or above, the port's error output is high. A read then returns zero, and a write changes no register.
- R7: A write and a read of the same lane in the same cycle return the old value. The new value is visible in the next cycle.
- R8: For each index i below VL with predicate bit i set, the sequencer writes (src1[i] + src2[i]) mod 2^w into destination lane i. Lanes whose predicate bit is clear keep their value.
- R9: `op_busy` is high for exactly VL cycles, one element per cycle. `op_done` is high for one cycle right after the last element. A start with VL=0 gives `op_done` on the next cycle and writes nothing.
- R10: An external write offered while `op_busy` is high is ignored.
- R11: With a scalar destination (`op_dvec`=0), each enabled element overwrites the whole destination register. The register ends up holding the sum of the last enabled element.
- R12: An enabled element whose source or destination lands beyond register 127 raises `op_err` in the cycle it is processed. Its write is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_reg | input | 7 | Read port base register |
| rd_ew | input | 2 | Read port width code |
| rd_off | input | 7 | Read port element offset |
| rd_data | output | 64 | Selected lane, zero-extended |
| rd_err | output | 1 | Read lands beyond the last register |
| wr_en | input | 1 | External write request |
| wr_vec | input | 1 | 1: lane write, 0: whole-register write |
| wr_reg | input | 7 | Write port base register |
| wr_ew | input | 2 | Write port width code |
| wr_off | input | 7 | Write port element offset |
| wr_data | input | 64 | Write value (low lane bits used) |
| wr_err | output | 1 | Requested write lands beyond the last register |
| op_start | input | 1 | Start a sequenced add (ignored while busy) |
| op_vl | input | 7 | Element count, 0 to 64 |
| op_pred | input | 64 | Per-element enable mask |
| op_src1 | input | 7 | First source base register |
| op_src2 | input | 7 | Second source base register |
| op_dst | input | 7 | Destination base register |
| op_ew | input | 2 | Width code used by the sequenced add |
| op_dvec | input | 1 | Destination is a vector (1) or scalar (0) |
| op_busy | output | 1 | Sequencer is stepping elements |
| op_done | output | 1 | One-cycle pulse after the last element |
| op_err | output | 1 | Current element is out of range and suppressed |

## Verification
The bench writes and reads every offset of every width across a register boundary. A design that computes lane positions wrongly, or that spills into the next register at the wrong offset, shows up as a mismatch in the neighbouring lanes or registers.

It issues a scalar write with a nonzero offset into a register that is all ones. A design that keeps the old high bits, or that honours the offset, fails this check. It also issues an out-of-range write whose index would wrap around to register 0. A design that drops the error check corrupts that register.

The sequenced runs cover sparse predicates, VL of zero and of 64, a scalar destination, and sources that overlap the destination. A design that writes disabled lanes, counts cycles wrongly, wraps the sum at the wrong width, or lets an external write slip in mid-run leaves different register contents from the arithmetic model.

// File: rtl/ewrf_pkg.sv
// Package: shared encodings for the element-width register file.
// Assumes a 2-bit width code; the lane sizes are fixed by that code.
package ewrf_pkg;
    typedef enum logic [1:0] {
        EW_FULL = 2'd0,
        EW_BYTE = 2'd1,
        EW_HALF = 2'd2,
        EW_WORD = 2'd3
    } ew_e;
endpackage

// File: rtl/ewrf_lane_map.sv
// Lane mapper: turns (base register, width code, element offset) into a
// physical register, a bit shift and an unshifted lane mask. The offset is
// ignored for scalar accesses. Assumes XLEN >= 32 and NREG a power of two.
module ewrf_lane_map
    import ewrf_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int NREG  = 128,
    parameter int OFF_W = 7,
    localparam int REG_W = $clog2(NREG),
    localparam int SH_W  = $clog2(XLEN)
) (
    input  logic [REG_W-1:0] reg_i,
    input  logic [1:0]       ew_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             vec_i,
    output logic [REG_W-1:0] phys_o,
    output logic [SH_W-1:0]  shift_o,
    output logic [XLEN-1:0]  emask_o,
    output logic             err_o
);
    localparam int SUM_W = ((REG_W > OFF_W) ? REG_W : OFF_W) + 1;

    logic [SH_W:0]    bw_l2;
    logic [SH_W:0]    lanes_l2;
    logic [SUM_W-1:0] off_w;
    logic [SUM_W-1:0] step_w;
    logic [SUM_W-1:0] lane_w;
    logic [SUM_W-1:0] sum_w;

    // Decode the width and split the offset into register step and lane.
    always_comb begin
        unique case (ew_e'(ew_i))
            EW_BYTE: bw_l2 = (SH_W+1)'(3);
            EW_HALF: bw_l2 = (SH_W+1)'(4);
            EW_WORD: bw_l2 = (SH_W+1)'(5);
            default: bw_l2 = (SH_W+1)'(SH_W);
        endcase
        lanes_l2 = (SH_W+1)'(SH_W) - bw_l2;
        off_w    = vec_i ? SUM_W'(off_i) : '0;
        step_w   = off_w >> lanes_l2;
        lane_w   = off_w & ((SUM_W'(1) << lanes_l2) - SUM_W'(1));
        sum_w    = SUM_W'(reg_i) + step_w;
        err_o    = (sum_w >= SUM_W'(NREG));
        phys_o   = sum_w[REG_W-1:0];
        shift_o  = SH_W'(lane_w << bw_l2);
        emask_o  = ~({XLEN{1'b1}} << (1 << bw_l2));
    end
endmodule

// File: rtl/ewrf_bank.sv
// Register bank: NREG words of XLEN bits, NRD combinational read ports and
// one bit-masked write port. Reads see the value before a same-cycle write.
module ewrf_bank #(
    parameter int XLEN = 64,
    parameter int NREG = 128,
    parameter int NRD  = 3,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [REG_W-1:0]          waddr_i,
    input  logic [XLEN-1:0]           wmask_i,
    input  logic [XLEN-1:0]           wdata_i,
    input  logic [NRD-1:0][REG_W-1:0] raddr_i,
    output logic [NRD-1:0][XLEN-1:0]  rdata_o
);
    logic [XLEN-1:0] regs [NREG];

    // Clear on reset, otherwise merge the masked write into one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we_i) begin
            regs[waddr_i] <= (regs[waddr_i] & ~wmask_i) | (wdata_i & wmask_i);
        end
    end

    // One combinational read path per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = regs[raddr_i[p]];
    end
endmodule

// File: rtl/ewrf_seq.sv
// Element sequencer: after a start pulse, steps an index from 0 to VL-1,
// one index per cycle, and reports whether the current element is enabled
// by the latched predicate. Start is ignored while busy; VL is clamped to
// MAXVL. Assumes MAXVL is a power of two.
module ewrf_seq #(
    parameter int MAXVL = 64,
    localparam int VL_W = $clog2(MAXVL + 1),
    localparam int PI_W = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [MAXVL-1:0] pred_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [VL_W-1:0]  idx_o,
    output logic             step_o
);
    logic [VL_W-1:0]  vl_q;
    logic [MAXVL-1:0] pred_q;
    logic [VL_W-1:0]  vl_c;

    // Clamp the requested length to the supported maximum.
    assign vl_c = (vl_i > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl_i;

    // Run/idle control, index counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
            vl_q   <= '0;
            pred_q <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    vl_q   <= vl_c;
                    pred_q <= pred_i;
                    idx_o  <= '0;
                    if (vl_c == '0) done_o <= 1'b1;
                    else            busy_o <= 1'b1;
                end
            end else begin
                if (idx_o == VL_W'(vl_q - 1'b1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
                idx_o <= idx_o + 1'b1;
            end
        end
    end

    // Current element is live when running and its predicate bit is set.
    assign step_o = busy_o && pred_q[idx_o[PI_W-1:0]];
endmodule

// File: rtl/ewrf_top.sv
// Element-width polymorphic register file with one external read port, one
// external write port and a predicated element-wise add sequencer. The
// sequencer owns the single write port while busy. Assumes MAXVL <= NREG.
module ewrf_top #(
    parameter int XLEN  = 64,
    parameter int NREG  = 128,
    parameter int MAXVL = 64,
    localparam int REG_W = $clog2(NREG),
    localparam int OFF_W = $clog2(NREG),
    localparam int VL_W  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rd_reg,
    input  logic [1:0]       rd_ew,
    input  logic [OFF_W-1:0] rd_off,
    output logic [XLEN-1:0]  rd_data,
    output logic             rd_err,
    input  logic             wr_en,
    input  logic             wr_vec,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [1:0]       wr_ew,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err,
    input  logic             op_start,
    input  logic [VL_W-1:0]  op_vl,
    input  logic [MAXVL-1:0] op_pred,
    input  logic [REG_W-1:0] op_src1,
    input  logic [REG_W-1:0] op_src2,
    input  logic [REG_W-1:0] op_dst,
    input  logic [1:0]       op_ew,
    input  logic             op_dvec,
    output logic             op_busy,
    output logic             op_done,
    output logic             op_err
);
    localparam int SH_W = $clog2(XLEN);
    localparam int NRD  = 3;

    // Port indices into the bank read ports.
    localparam int P_EXT = 0;
    localparam int P_S1  = 1;
    localparam int P_S2  = 2;

    logic [REG_W-1:0] s1_q, s2_q, d_q;
    logic [1:0]       ew_q;
    logic             dvec_q;
    logic [VL_W-1:0]  idx;
    logic             step;
    logic [OFF_W-1:0] s_off;

    logic [REG_W-1:0] rd_phys, wx_phys, s1_phys, s2_phys, d_phys;
    logic [SH_W-1:0]  rd_sh, wx_sh, s1_sh, s2_sh, d_sh;
    logic [XLEN-1:0]  rd_mask, wx_mask, s1_mask, s2_mask, d_mask;
    logic             wx_err, s1_err, s2_err, d_err;

    logic [NRD-1:0][REG_W-1:0] raddr;
    logic [NRD-1:0][XLEN-1:0]  rdata;

    logic [XLEN-1:0]  op_a, op_b, op_sum;
    logic             seq_we, ext_we;
    logic             w_en, w_vec;
    logic [REG_W-1:0] w_phys;
    logic [SH_W-1:0]  w_sh;
    logic [XLEN-1:0]  w_emask, w_val, w_trim, w_mask, w_data;

    // Capture operand fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            d_q    <= '0;
            ew_q   <= '0;
            dvec_q <= 1'b0;
        end else if (op_start && !op_busy) begin
            s1_q   <= op_src1;
            s2_q   <= op_src2;
            d_q    <= op_dst;
            ew_q   <= op_ew;
            dvec_q <= op_dvec;
        end
    end

    ewrf_seq #(.MAXVL(MAXVL)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(op_start), .vl_i(op_vl),
        .pred_i(op_pred), .busy_o(op_busy), .done_o(op_done),
        .idx_o(idx), .step_o(step)
    );

    assign s_off = OFF_W'(idx);

    ewrf_lane_map #(.XLEN(XLEN), .NREG(NREG), .OFF_W(OFF_W)) u_map_rd (
        .reg_i(rd_reg), .ew_i(rd_ew), .off_i(rd_off), .vec_i(1'b1),
        .phys_o(rd_phys), .shift_o(rd_sh), .emask_o(rd_mask), .err_o(rd_err)
    );
    ewrf_lane_map #(.XLEN(XLEN), .NREG(NREG), .OFF_W(OFF_W)) u_map_wr (
        .reg_i(wr_reg), .ew_i(wr_ew), .off_i(wr_off), .vec_i(wr_vec),
        .phys_o(wx_phys), .shift_o(wx_sh), .emask_o(wx_mask), .err_o(wx_err)
    );
    ewrf_lane_map #(.XLEN(XLEN), .NREG(NREG), .OFF_W(OFF_W)) u_map_s1 (
        .reg_i(s1_q), .ew_i(ew_q), .off_i(s_off), .vec_i(1'b1),
        .phys_o(s1_phys), .shift_o(s1_sh), .emask_o(s1_mask), .err_o(s1_err)
    );
    ewrf_lane_map #(.XLEN(XLEN), .NREG(NREG), .OFF_W(OFF_W)) u_map_s2 (
        .reg_i(s2_q), .ew_i(ew_q), .off_i(s_off), .vec_i(1'b1),
        .phys_o(s2_phys), .shift_o(s2_sh), .emask_o(s2_mask), .err_o(s2_err)
    );
    ewrf_lane_map #(.XLEN(XLEN), .NREG(NREG), .OFF_W(OFF_W)) u_map_d (
        .reg_i(d_q), .ew_i(ew_q), .off_i(s_off), .vec_i(dvec_q),
        .phys_o(d_phys), .shift_o(d_sh), .emask_o(d_mask), .err_o(d_err)
    );

    assign raddr[P_EXT] = rd_phys;
    assign raddr[P_S1]  = s1_phys;
    assign raddr[P_S2]  = s2_phys;

    ewrf_bank #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(w_en), .waddr_i(w_phys),
        .wmask_i(w_mask), .wdata_i(w_data), .raddr_i(raddr), .rdata_o(rdata)
    );

    // External read: extract the lane and zero out-of-range results.
    assign rd_data = rd_err ? '0 : ((rdata[P_EXT] >> rd_sh) & rd_mask);

    // Demonstration add: extract both lanes and wrap at the lane width.
    assign op_a   = (rdata[P_S1] >> s1_sh) & s1_mask;
    assign op_b   = (rdata[P_S2] >> s2_sh) & s2_mask;
    assign op_sum = (op_a + op_b) & d_mask;

    // Error flags and write qualifiers for both writers.
    assign op_err = step && (s1_err || s2_err || d_err);
    assign seq_we = step && !(s1_err || s2_err || d_err);
    assign wr_err = wr_en && wx_err;
    assign ext_we = wr_en && !wx_err && !op_busy;

    // Select the write source and build the lane-positioned mask and data.
    always_comb begin
        if (op_busy) begin
            w_en    = seq_we;
            w_phys  = d_phys;
            w_sh    = d_sh;
            w_emask = d_mask;
            w_vec   = dvec_q;
            w_val   = op_sum;
        end else begin
            w_en    = ext_we;
            w_phys  = wx_phys;
            w_sh    = wx_sh;
            w_emask = wx_mask;
            w_vec   = wr_vec;
            w_val   = wr_data;
        end
        w_trim = w_val & w_emask;
        w_mask = w_vec ? (w_emask << w_sh) : '1;
        w_data = w_vec ? (w_trim << w_sh) : w_trim;
    end
endmodule

// File: rtl/ewrf_chk.sv
// Checker: port-level properties of the register file, attached by bind.
module ewrf_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      rd_ew,
    input logic [XLEN-1:0] rd_data,
    input logic            rd_err,
    input logic            op_busy,
    input logic            op_done,
    input logic            op_err
);
    AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0)); // R6

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ew == 2'd1) |-> (rd_data[XLEN-1:8] == '0)); // R2

    AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ew == 2'd2) |-> (rd_data[XLEN-1:16] == '0)); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !op_busy); // R9

    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(op_busy) |-> op_done); // R9

    AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_busy); // R12
endmodule

bind ewrf_top ewrf_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_ew(rd_ew), .rd_data(rd_data),
    .rd_err(rd_err), .op_busy(op_busy), .op_done(op_done), .op_err(op_err)
);

// File: tb/sim_ewrf_top.sv
`timescale 1ns/1ps
module sim_ewrf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rd_reg = '0;
    logic [1:0]  rd_ew = '0;
    logic [6:0]  rd_off = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic        wr_en = 1'b0;
    logic        wr_vec = 1'b0;
    logic [6:0]  wr_reg = '0;
    logic [1:0]  wr_ew = '0;
    logic [6:0]  wr_off = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic        op_start = 1'b0;
    logic [6:0]  op_vl = '0;
    logic [63:0] op_pred = '0;
    logic [6:0]  op_src1 = '0;
    logic [6:0]  op_src2 = '0;
    logic [6:0]  op_dst = '0;
    logic [1:0]  op_ew = '0;
    logic        op_dvec = 1'b0;
    logic        op_busy;
    logic        op_done;
    logic        op_err;

    int nchk = 0;
    int nfail = 0;
    bit ended = 0;
    logic [63:0] mdl [128];

    always #5 clk = ~clk;

    ewrf_top u0 (.*);

    function automatic int bw_of(int ew);
        return (ew == 1) ? 8 : (ew == 2) ? 16 : (ew == 3) ? 32 : 64;
    endfunction

    function automatic logic [63:0] lmask(int bw);
        return (bw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bw) - 64'd1);
    endfunction

    function automatic int phys_of(int r, int ew, int off);
        return r + off / (64 / bw_of(ew));
    endfunction

    function automatic int pos_of(int ew, int off);
        return (off % (64 / bw_of(ew))) * bw_of(ew);
    endfunction

    function automatic logic [63:0] mget(int r, int ew, int off);
        int p;
        p = phys_of(r, ew, off);
        if (p >= 128) return 64'd0;
        return (mdl[p] >> pos_of(ew, off)) & lmask(bw_of(ew));
    endfunction

    task automatic mput(int r, int ew, int off, bit vec, logic [63:0] v);
        int p;
        logic [63:0] m;
        m = lmask(bw_of(ew));
        if (!vec) begin
            mdl[r] = v & m;
        end else begin
            p = phys_of(r, ew, off);
            if (p < 128)
                mdl[p] = (mdl[p] & ~(m << pos_of(ew, off))) | ((v & m) << pos_of(ew, off));
        end
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ext_write(int r, int ew, int off, bit vec, logic [63:0] v);
        bit exp_err;
        @(negedge clk);
        wr_en = 1'b1; wr_vec = vec; wr_reg = 7'(r); wr_ew = 2'(ew);
        wr_off = 7'(off); wr_data = v;
        #1;
        exp_err = vec && (phys_of(r, ew, off) >= 128);
        check("R6 wr_err", 64'(wr_err), 64'(exp_err));
        mput(r, ew, off, vec, v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(int r, int ew, int off, string req);
        @(negedge clk);
        rd_reg = 7'(r); rd_ew = 2'(ew); rd_off = 7'(off);
        #1;
        check(req, rd_data, mget(r, ew, off));
        check("R6 rd_err", 64'(rd_err), 64'(phys_of(r, ew, off) >= 128));
    endtask

    task automatic run_op(int s1, int s2, int d, int ew, bit dvec, int vl,
                          logic [63:0] pred, bit poke, string req);
        int waits;
        int errc;
        int eerr;
        logic [63:0] sum;
        @(negedge clk);
        op_src1 = 7'(s1); op_src2 = 7'(s2); op_dst = 7'(d); op_ew = 2'(ew);
        op_dvec = dvec; op_vl = 7'(vl); op_pred = pred; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        if (poke) begin
            wr_en = 1'b1; wr_vec = 1'b0; wr_reg = 7'd90; wr_ew = 2'd0;
            wr_off = 7'd0; wr_data = 64'hDEAD;
        end
        waits = 0;
        errc = 0;
        while (!op_done && waits < 300) begin
            if (op_err) errc++;
            @(negedge clk);
            waits++;
            if (waits == 1) wr_en = 1'b0;
        end
        wr_en = 1'b0;
        eerr = 0;
        for (int i = 0; i < vl; i++) begin
            if (pred[i]) begin
                if (phys_of(s1, ew, i) >= 128 || phys_of(s2, ew, i) >= 128 ||
                    (dvec && phys_of(d, ew, i) >= 128)) begin
                    eerr++;
                end else begin
                    sum = (mget(s1, ew, i) + mget(s2, ew, i)) & lmask(bw_of(ew));
                    mput(d, ew, i, dvec, sum);
                end
            end
        end
        check("R9 cycles", 64'(waits), 64'(vl));
        check("R9 done", 64'(op_done), 64'd1);
        check("R9 busy", 64'(op_busy), 64'd0);
        check("R12 errs", 64'(errc), 64'(eerr));
        for (int k = 0; k < 8; k++) begin
            if (d + k < 128) rd_check(d + k, 0, 0, req);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!ended) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs and cleared storage
        check("R1 busy", 64'(op_busy), 64'd0);
        check("R1 done", 64'(op_done), 64'd0);
        for (int r = 0; r < 128; r++) rd_check(r, 0, 0, "R1");

        // R2 and R5: every lane of every width across two registers
        ext_write(10, 0, 0, 0, 64'h0123_4567_89AB_CDEF);
        ext_write(11, 0, 0, 0, 64'hFEDC_BA98_7654_3210);
        for (int ew = 0; ew < 4; ew++) begin
            for (int off = 0; off < 2 * (64 / bw_of(ew)); off++) begin
                rd_check(10, ew, off, (off < 64 / bw_of(ew)) ? "R2" : "R5");
            end
        end

        // R3: lane writes touch only their lane, including spill into reg 21
        for (int ew = 0; ew < 4; ew++) begin
            ext_write(20, 0, 0, 0, 64'hFFFF_0000_FFFF_0000 ^ 64'(ew));
            ext_write(21, 0, 0, 0, 64'h0F0F_F0F0_3333_CCCC ^ 64'(ew));
            for (int off = 0; off < 2 * (64 / bw_of(ew)); off++) begin
                ext_write(20, ew, off, 1, 64'hC3C3_C3C3_C3C3_C3C3 + 64'(off) * 64'h0101_0101_0101_0103);
                rd_check(20, 0, 0, "R3");
                rd_check(21, 0, 0, "R3");
                rd_check(22, 0, 0, "R3");
            end
        end

        // R4: scalar write replaces all bits, offset ignored
        ext_write(30, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        ext_write(31, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        ext_write(30, 1, 12, 0, 64'h1234);
        rd_check(30, 0, 0, "R4");
        check("R4 value", mdl[30], 64'h34);
        rd_check(31, 0, 0, "R4");

        // R6: out-of-range write would wrap to reg 0 if not suppressed
        ext_write(0, 0, 0, 0, 64'h5555_AAAA_5555_AAAA);
        ext_write(127, 1, 8, 1, 64'hEE);
        ext_write(120, 2, 40, 1, 64'hBEEF);
        rd_check(0, 0, 0, "R6");
        rd_check(127, 1, 8, "R6");
        rd_check(126, 3, 5, "R6");

        // R7: same-cycle read and write of one lane
        ext_write(40, 0, 0, 0, 64'h1111_2222_3333_4444);
        @(negedge clk);
        wr_en = 1'b1; wr_vec = 1'b1; wr_reg = 7'd40; wr_ew = 2'd2; wr_off = 7'd1;
        wr_data = 64'hBEEF; rd_reg = 7'd40; rd_ew = 2'd2; rd_off = 7'd1;
        #1;
        check("R7 old", rd_data, 64'h3333);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check("R7 new", rd_data, 64'hBEEF);
        mput(40, 2, 1, 1, 64'hBEEF);

        // R8: sequenced add, sources and destination preset
        for (int r = 50; r < 70; r++)
            ext_write(r, 0, 0, 0, 64'h9E37_79B9_7F4A_7C15 * 64'(r + 1));
        ext_write(90, 0, 0, 0, 64'h77);
        run_op(50, 54, 60, 1, 1, 16, 64'hA5A5, 0, "R8 byte");
        run_op(50, 54, 60, 2, 1, 16, 64'h0F0F, 1, "R8 half");
        rd_check(90, 0, 0, "R10");
        run_op(50, 54, 60, 3, 1, 9, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 word");
        run_op(50, 54, 60, 0, 1, 8, 64'h5B, 0, "R8 full");
        run_op(50, 51, 60, 0, 1, 16, 64'hFFFF, 0, "R8 overlap");
        run_op(50, 51, 60, 1, 1, 64, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 vl64");
        run_op(50, 51, 60, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R9 vl0");
        run_op(52, 53, 70, 2, 0, 5, 64'b10110, 0, "R11");
        run_op(50, 51, 120, 0, 1, 12, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R12");

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule